// File: doc/BRIEF.md
# Sequential Non-Restoring Unsigned Divider

This block divides one unsigned integer by another over several clock cycles and returns the quotient and the remainder. A caller presents both operands with a one-cycle `start` pulse. The block latches the operands and then settles one quotient bit per clock. When the results are ready it raises `done` for one cycle. It never runs a separate cycle to restore a partial remainder. Each iteration either adds or subtracts the divisor, and the sign of the previous partial remainder decides which. The quotient bits collect in the lower half of the shared shift register, and the upper half holds the partial remainder.

The partial remainder is kept one bit wider than the operands so that its sign is always known. After the last iteration, one fix-up cycle adds the divisor back if the partial remainder is negative. A zero divisor skips the iteration entirely and reports the result at once with a flag.

Top module: `nr_divider`

## Requirements
- R1: While reset is asserted and in the first cycle after it, `busy`, `done`, `div_by_zero`, `quotient` and `remainder` are all zero.
- R2: A `start` accepted while idle with a nonzero divisor raises `busy` on the next clock edge. `busy` stays high for W+1 cycles. `done` is high for exactly one cycle, starting at the same edge at which `busy` falls. `busy` and `done` are never high together.
- R3: On completion, `quotient` equals floor(dividend / divisor) and `remainder` equals dividend mod divisor, both treated as unsigned W-bit values. This covers operands with the top bit set, a divisor larger than the dividend, and a zero dividend.
- R4: A `start` with divisor zero completes at the next edge without raising `busy`. It sets `div_by_zero` to 1, `quotient` to all ones and `remainder` to the dividend.
- R5: A `start` that arrives while `busy` is high is ignored. The run in progress completes with the results of its own operands, and no extra run follows it.
- R6: `quotient`, `remainder` and `div_by_zero` change only at the edge that raises `done`, and hold their values between completions.
- R7: With W = 4, dividing 7 by 2 gives quotient 3 and remainder 1.
- R8: A completion with a nonzero divisor clears `div_by_zero`.
- R9: After every iteration the signed partial remainder lies in [-divisor, divisor). On completion with a nonzero divisor, `remainder` is below the divisor.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a division; accepted only while idle |
| dividend | input | W | Unsigned dividend, sampled with start |
| divisor | input | W | Unsigned divisor, sampled with start |
| busy | output | 1 | An iteration or the fix-up cycle is in progress |
| done | output | 1 | One-cycle pulse when results are updated |
| quotient | output | W | Quotient of the last completed division |
| remainder | output | W | Remainder of the last completed division |
| div_by_zero | output | 1 | The last completed division had a zero divisor |

## Verification
The assertions take three things for granted. Reset is held low from time zero. `start` and the operands carry known values whenever `start` is sampled high. The operands need to be valid only in the cycle in which `start` is accepted, because the block latches them. The bench changes every input on the falling clock edge. It pulses `start` for one cycle, and it holds `start` high while the block is busy only to exercise R5. It never leaves an operand unknown during a start cycle.

// File: rtl/nr_divider.sv
module nr_divider #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [W-1:0] dividend,
  input  logic [W-1:0] divisor,
  output logic         busy,
  output logic         done,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         div_by_zero
);

  localparam int CW = (W > 2) ? $clog2(W) : 1;

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIX} state_t;

  state_t        state;
  logic [CW-1:0] cnt;
  logic [W:0]    part;
  logic [W-1:0]  qacc;
  logic [W-1:0]  dvs;
  logic [W:0]    shifted;
  logic [W:0]    step;
  logic [W:0]    fixed;

  assign busy    = (state != S_IDLE);
  assign shifted = {part[W-1:0], qacc[W-1]};
  assign step    = part[W] ? shifted + {1'b0, dvs} : shifted - {1'b0, dvs};
  assign fixed   = part + {1'b0, dvs};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state       <= S_IDLE;
      cnt         <= '0;
      part        <= '0;
      qacc        <= '0;
      dvs         <= '0;
      done        <= 1'b0;
      quotient    <= '0;
      remainder   <= '0;
      div_by_zero <= 1'b0;
    end else begin
      done <= 1'b0;
      case (state)
        S_IDLE: if (start) begin
          if (divisor == '0) begin
            quotient    <= '1;
            remainder   <= dividend;
            div_by_zero <= 1'b1;
            done        <= 1'b1;
          end else begin
            part  <= '0;
            qacc  <= dividend;
            dvs   <= divisor;
            cnt   <= '0;
            state <= S_RUN;
          end
        end
        S_RUN: begin
          part <= step;
          qacc <= {qacc[W-2:0], ~step[W]};
          cnt  <= cnt + 1'b1;
          if (cnt == CW'(W - 1)) state <= S_FIX;
        end
        S_FIX: begin
          quotient    <= qacc;
          remainder   <= part[W] ? fixed[W-1:0] : part[W-1:0];
          div_by_zero <= 1'b0;
          done        <= 1'b1;
          state       <= S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  a_r2_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  a_r2_busy_done_apart: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r9_partial_bound: assert property (@(posedge clk) disable iff (!rst_n)
    (state != S_IDLE && $past(state) == S_RUN) |->
      ($signed({part[W], part}) <  $signed({2'b00, dvs}) &&
       $signed({part[W], part}) >= -$signed({2'b00, dvs})));

  a_r9_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !div_by_zero) |-> (remainder < dvs));

  a_r4_zero_quotient: assert property (@(posedge clk) disable iff (!rst_n)
    (done && div_by_zero) |-> (quotient == '1));

  a_r6_hold_results: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> ($stable(quotient) && $stable(remainder) && $stable(div_by_zero)));

endmodule

// File: tb/nr_divider_bench.sv
module nr_divider_bench;
  localparam int W = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [W-1:0] dividend = '0, divisor = '0;
  logic busy, done, dbz;
  logic [W-1:0] quotient, remainder;

  logic s4 = 1'b0;
  logic [3:0] a4 = '0, b4 = '0;
  logic busy4, done4, dbz4;
  logic [3:0] q4, r4;

  int checks = 0, errors = 0, cyc = 0;

  always #2 clk = ~clk;

  nr_divider #(.W(W)) u_nr_divider (
    .clk(clk), .rst_n(rst_n), .start(start), .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done), .quotient(quotient), .remainder(remainder), .div_by_zero(dbz));

  nr_divider #(.W(4)) u_nr_divider_w4 (
    .clk(clk), .rst_n(rst_n), .start(s4), .dividend(a4), .divisor(b4),
    .busy(busy4), .done(done4), .quotient(q4), .remainder(r4), .div_by_zero(dbz4));

  // reference model
  bit m_busy, m_done, m_z;
  int m_cnt;
  logic [W-1:0] m_a, m_b, m_q, m_r;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_done = 0; m_z = 0; m_cnt = 0; m_q = '0; m_r = '0;
    end else begin
      m_done = 0;
      if (!m_busy && start) begin
        if (divisor == '0) begin
          m_done = 1; m_q = '1; m_r = dividend; m_z = 1;
        end else begin
          m_busy = 1; m_cnt = W + 1; m_a = dividend; m_b = divisor;
        end
      end else if (m_busy) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_busy = 0; m_done = 1; m_z = 0;
          m_q = m_a / m_b; m_r = m_a % m_b;
        end
      end
    end
  end

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk("R2 busy", W'(busy), W'(m_busy));
    chk("R2 done", W'(done), W'(m_done));
    chk("R3 quotient", quotient, m_q);
    chk("R3 remainder", remainder, m_r);
    chk("R4 div_by_zero", W'(dbz), W'(m_z));
    if (done && !dbz) chk("R9 remainder below divisor", W'(remainder < m_b), W'(1));
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic run(input logic [W-1:0] a, input logic [W-1:0] b);
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    logic [W-1:0] lfsr;
    repeat (3) @(negedge clk);
    // R1 reset values
    chk("R1 busy", W'(busy), '0);
    chk("R1 done", W'(done), '0);
    chk("R1 quotient", quotient, '0);
    chk("R1 remainder", remainder, '0);
    chk("R1 div_by_zero", W'(dbz), '0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after release", W'(busy | done | dbz), '0);

    run(32'd100, 32'd7);
    run(32'hFFFF_FFFF, 32'd1);
    run(32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run(32'd0, 32'd5);
    run(32'd5, 32'd9);
    run(32'h8000_0000, 32'd3);
    run(32'hFFFF_FFFE, 32'h8000_0001);
    // R4 zero divisor, then R8 clear
    run(32'd1234, 32'd0);
    chk("R4 flag set", W'(dbz), W'(1));
    chk("R4 remainder is dividend", remainder, 32'd1234);
    run(32'd50, 32'd8);
    chk("R8 flag cleared", W'(dbz), '0);
    chk("R3 50/8", quotient, 32'd6);

    // R5 start while busy is ignored
    @(negedge clk);
    dividend = 32'd1000; divisor = 32'd10; start = 1'b1;
    @(negedge clk);
    dividend = 32'd77; divisor = 32'd0;
    repeat (5) @(negedge clk);
    start = 1'b0;
    while (busy) @(negedge clk);
    chk("R5 first operands kept", quotient, 32'd100);
    @(negedge clk);
    chk("R5 no extra run", W'(busy), '0);

    // R6 hold after completion
    repeat (6) @(negedge clk);
    chk("R6 quotient held", quotient, 32'd100);
    chk("R6 remainder held", remainder, 32'd0);

    lfsr = 32'h1D2C_3B4A;
    for (int i = 0; i < 40; i++) begin
      logic [W-1:0] a, b;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      a = lfsr;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      b = (i % 3 == 0) ? (lfsr >> (i % 29)) : lfsr;
      run(a, b);
    end

    // R7 four-bit configuration
    @(negedge clk);
    a4 = 4'd7; b4 = 4'd2; s4 = 1'b1;
    @(negedge clk);
    s4 = 1'b0;
    for (int k = 0; k < 20 && !done4; k++) @(negedge clk);
    chk("R7 done", W'(done4), W'(1));
    chk("R7 quotient", W'(q4), W'(3));
    chk("R7 remainder", W'(r4), W'(1));

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule